// File: doc/BRIEF.md
# Size-Checked Status Register Window

This block is the slave end of a simple peripheral bus for a small bank of identification and captured-status registers. A requester presents an offset, a read/write flag, an access size and write data for one cycle. On the following clock the block answers with a one-cycle done pulse, an error flag and read data. An error answer always carries zero read data.

Two 16-bit identification registers, core type at offset 0x0000 and revision at offset 0x0002, read straight from module input pins and never depend on reset. Three status registers load together from capture inputs whenever a capture strobe is high: an 8-bit master value at 0x66, an 8-bit attribute value at 0x67 and a 32-bit data value at 0x6C. Active-low reset clears them. Every register is read-only from the bus. The block decides whether each request is legal. A write of exactly the register's own width is dropped without an error. A write of any other width, or any access to an unassigned offset, ends in an error.

Top module: `periph_reg_window`

## Requirements
- R1: Any read or write at an offset that holds no register (0x0004–0x0065, 0x0068–0x006B, 0x0070–0x3FFF) gets an error response with zero read data.
- R2: Each request held for one cycle gets exactly one done pulse on the next clock, and done stays low when there is no request.
- R3: The size code is 2'b00 byte, 2'b01 halfword, 2'b10 word. Code 2'b11 always gets an error.
- R4: The identification registers follow their inputs. A halfword read at 0x0000 returns the core type on bits [15:0], a halfword read at 0x0002 returns the revision on bits [31:16], and all other lanes read zero.
- R5: A read smaller than the register it falls in returns only the addressed bytes on lanes addr[1:0] upward, with byte lane k on bits [8k+7:8k], and zeros elsewhere.
- R6: A read that is not naturally aligned, or that is wider than the register holding its first byte, gets an error.
- R7: With the strobe high at a clock edge, the master, attribute and data registers load the capture inputs. Byte reads at 0x66 and 0x67 return them on lanes 2 and 3, and a word read at 0x6C returns the data value.
- R8: An aligned write whose size equals the target register's width completes without an error, returns zero data and leaves the register unchanged.
- R9: An aligned write whose size differs from the target register's width gets an error and leaves the register unchanged.
- R10: Reset clears the capture-loaded registers to zero. The identification registers show their input values with no dependence on reset.
- R11: A read accepted in the same cycle as a capture strobe returns the value from before the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Byte offset inside the window |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data (never stored) |
| core_id | input | 16 | Core type value |
| rev_id | input | 16 | Revision value |
| cap_strobe | input | 1 | Load the capture registers |
| cap_master | input | 8 | Captured master value |
| cap_attr | input | 8 | Captured attribute value |
| cap_data | input | 32 | Captured data value |
| rsp_done | output | 1 | Response pulse, one cycle after the request |
| rsp_err | output | 1 | Response ended in error |
| rsp_rdata | output | 32 | Read data, zero on error or write |

## Verification
A fault in the decode or in the capture registers shows at the ports on the very next response. A wrong width table flips the error flag for a size that should pass. A wrong lane mask puts data on byte lanes that should be zero. A stray write path shows on the next read of 0x6C or 0x66 as a value that no strobe provided. The bench reads every register back after each class of dropped or rejected write, so a corrupted register appears within two requests of the fault.

// File: rtl/periph_reg_window.sv
module periph_reg_window #(
  parameter int AW = 14,
  parameter int DW = 32,
  parameter int IDW = 16,
  parameter int SW = 8,
  parameter logic [13:0] OFS_CORE = 14'h0000,
  parameter logic [13:0] OFS_REV  = 14'h0002,
  parameter logic [13:0] OFS_MST  = 14'h0066,
  parameter logic [13:0] OFS_ATR  = 14'h0067,
  parameter logic [13:0] OFS_DAT  = 14'h006C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_wdata,
  input  logic [IDW-1:0] core_id,
  input  logic [IDW-1:0] rev_id,
  input  logic          cap_strobe,
  input  logic [SW-1:0] cap_master,
  input  logic [SW-1:0] cap_attr,
  input  logic [DW-1:0] cap_data,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  localparam int NB = DW / 8;

  logic [SW-1:0] mst_q, atr_q;
  logic [DW-1:0] dat_q;
  logic [2:0]    nbytes, rwidth;
  logic          aligned, size_ok, rd_ok, wr_ok, err_n;
  logic [DW-1:0] word, mask, rdata_n;
  logic [NB-1:0] lanes;
  logic          wdata_unused;

  assign wdata_unused = ^req_wdata;

  always_comb begin
    case (req_size)
      2'b00:   nbytes = 3'd1;
      2'b01:   nbytes = 3'd2;
      2'b10:   nbytes = 3'd4;
      default: nbytes = 3'd0;
    endcase
  end

  assign size_ok = (req_size != 2'b11);
  assign aligned = (req_size == 2'b00) ||
                   (req_size == 2'b01 && !req_addr[0]) ||
                   (req_size == 2'b10 && req_addr[1:0] == 2'b00);

  always_comb begin
    if (req_addr[AW-1:1] == OFS_CORE[AW-1:1] || req_addr[AW-1:1] == OFS_REV[AW-1:1])
      rwidth = 3'd2;
    else if (req_addr == OFS_MST || req_addr == OFS_ATR)
      rwidth = 3'd1;
    else if (req_addr[AW-1:2] == OFS_DAT[AW-1:2])
      rwidth = 3'd4;
    else
      rwidth = 3'd0;
  end

  assign rd_ok = size_ok && aligned && rwidth != 3'd0 && nbytes <= rwidth;
  assign wr_ok = size_ok && aligned && rwidth != 3'd0 && nbytes == rwidth;
  assign err_n = req_write ? !wr_ok : !rd_ok;

  always_comb begin
    if (req_addr[AW-1:2] == OFS_CORE[AW-1:2])
      word = {rev_id, core_id};
    else if (req_addr[AW-1:2] == OFS_MST[AW-1:2])
      word = {atr_q, mst_q, 16'h0000};
    else if (req_addr[AW-1:2] == OFS_DAT[AW-1:2])
      word = dat_q;
    else
      word = '0;
  end

  always_comb begin
    case (req_size)
      2'b00:   lanes = NB'(1) << req_addr[1:0];
      2'b01:   lanes = NB'(3) << {req_addr[1], 1'b0};
      default: lanes = '1;
    endcase
  end

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign mask[8*k +: 8] = {8{lanes[k]}};
  end

  assign rdata_n = (!err_n && !req_write) ? (word & mask) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_q     <= '0;
      atr_q     <= '0;
      dat_q     <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done  <= req_valid;
      rsp_err   <= req_valid && err_n;
      rsp_rdata <= req_valid ? rdata_n : '0;
      if (cap_strobe) begin
        mst_q <= cap_master;
        atr_q <= cap_attr;
        dat_q <= cap_data;
      end
    end
  end

  p_done_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done);
  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done);
  p_bad_size_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'b11) |=> (rsp_err && rsp_rdata == '0));
  p_write_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> rsp_rdata == '0);
  p_hold_without_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_strobe |=> ($stable(dat_q) && $stable(mst_q) && $stable(atr_q)));
  p_reserved_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= AW'(14'h0070)) |=> rsp_err);
endmodule

// File: tb/sim_periph_reg_window.sv
`timescale 1ns/1ps
module sim_periph_reg_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic [15:0] core_id = 16'hE012, rev_id = 16'h0104;
  logic        cap_strobe = 1'b0;
  logic [7:0]  cap_master = '0, cap_attr = '0;
  logic [31:0] cap_data = '0;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0, cycles = 0;
  bit    exp_err_q[$];
  logic [31:0] exp_dat_q[$];
  string exp_tag_q[$];

  always #2.5 clk = ~clk;

  periph_reg_window u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .core_id(core_id), .rev_id(rev_id), .cap_strobe(cap_strobe),
    .cap_master(cap_master), .cap_attr(cap_attr), .cap_data(cap_data),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

  task automatic req(input bit wr, input logic [13:0] a, input logic [1:0] sz,
                     input bit e_err, input logic [31:0] e_dat, input string tag,
                     input bit strobe = 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_wdata = 32'h5A5A_C3C3; cap_strobe = strobe;
    exp_err_q.push_back(e_err); exp_dat_q.push_back(e_dat); exp_tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; cap_strobe = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_done) begin
      checks++;
      if (exp_err_q.size() == 0) begin
        fails++;
        $display("FAIL R2 done without request: got done=1 expected done=0");
      end else begin
        automatic bit e = exp_err_q.pop_front();
        automatic logic [31:0] d = exp_dat_q.pop_front();
        automatic string t = exp_tag_q.pop_front();
        if (rsp_err !== e || rsp_rdata !== d) begin
          fails++;
          $display("FAIL %s: got err=%0b data=%h expected err=%0b data=%h",
                   t, rsp_err, rsp_rdata, e, d);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_done !== 1'b0 || rsp_err !== 1'b0 || rsp_rdata !== 32'h0) begin
      fails++;
      $display("FAIL R10 reset outputs: got %b %b %h expected 0 0 0", rsp_done, rsp_err, rsp_rdata);
    end
    rst_n = 1'b1;
    req(0, 14'h006C, 2'b10, 0, 32'h0, "R10 data cleared");
    req(0, 14'h0066, 2'b00, 0, 32'h0, "R10 master cleared");
    req(0, 14'h0000, 2'b10, 1, 32'h0, "R6 word straddles ids");
    req(0, 14'h0000, 2'b01, 0, 32'h0000_E012, "R4 core type");
    req(0, 14'h0002, 2'b01, 0, 32'h0104_0000, "R4 revision");
    req(0, 14'h0001, 2'b00, 0, 32'h0000_E000, "R5 byte core hi");
    req(0, 14'h0003, 2'b00, 0, 32'h0100_0000, "R5 byte rev hi");
    req(0, 14'h0001, 2'b01, 1, 32'h0, "R6 misaligned half");
    req(0, 14'h0000, 2'b11, 1, 32'h0, "R3 size code 11");
    req(0, 14'h0004, 2'b10, 1, 32'h0, "R1 reserved 0x04");
    req(0, 14'h0064, 2'b00, 1, 32'h0, "R1 reserved 0x64");
    req(0, 14'h0068, 2'b00, 1, 32'h0, "R1 reserved 0x68");
    req(0, 14'h0070, 2'b10, 1, 32'h0, "R1 reserved 0x70");
    req(0, 14'h3FFC, 2'b10, 1, 32'h0, "R1 reserved top");
    cap_master = 8'hA5; cap_attr = 8'h3C; cap_data = 32'hDEAD_BEEF;
    req(0, 14'h006C, 2'b10, 0, 32'h0, "R11 read with strobe", 1'b1);
    req(0, 14'h006C, 2'b10, 0, 32'hDEAD_BEEF, "R7 data");
    req(0, 14'h0066, 2'b00, 0, 32'h00A5_0000, "R7 master");
    req(0, 14'h0067, 2'b00, 0, 32'h3C00_0000, "R7 attributes");
    req(0, 14'h006C, 2'b01, 0, 32'h0000_BEEF, "R5 half data low");
    req(0, 14'h006F, 2'b00, 0, 32'hDE00_0000, "R5 byte data top");
    req(0, 14'h0066, 2'b01, 1, 32'h0, "R6 half across two bytes");
    req(1, 14'h006C, 2'b10, 0, 32'h0, "R8 word write dropped");
    req(0, 14'h006C, 2'b10, 0, 32'hDEAD_BEEF, "R8 data unchanged");
    req(1, 14'h0067, 2'b00, 0, 32'h0, "R8 byte write dropped");
    req(0, 14'h0067, 2'b00, 0, 32'h3C00_0000, "R8 attr unchanged");
    req(1, 14'h006D, 2'b00, 1, 32'h0, "R9 byte write to word reg");
    req(1, 14'h006C, 2'b01, 1, 32'h0, "R9 half write to word reg");
    req(1, 14'h0066, 2'b10, 1, 32'h0, "R9 word write to byte reg");
    req(0, 14'h006C, 2'b10, 0, 32'hDEAD_BEEF, "R9 data unchanged");
    req(0, 14'h0066, 2'b00, 0, 32'h00A5_0000, "R9 master unchanged");
    req(1, 14'h0000, 2'b01, 0, 32'h0, "R8 half write to id");
    req(1, 14'h0000, 2'b00, 1, 32'h0, "R9 byte write to id");
    req(1, 14'h0040, 2'b10, 1, 32'h0, "R1 reserved write");
    core_id = 16'h1234;
    req(0, 14'h0000, 2'b01, 0, 32'h0000_1234, "R4 follows input");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_done !== 1'b0) begin
      fails++;
      $display("FAIL R2 done in reset: got %b expected 0", rsp_done);
    end
    rst_n = 1'b1;
    req(0, 14'h006C, 2'b10, 0, 32'h0, "R10 data cleared again");
    req(0, 14'h0067, 2'b00, 0, 32'h0, "R10 attr cleared again");
    req(0, 14'h0002, 2'b01, 0, 32'h0104_0000, "R10 id kept across reset");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_err_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing responses: got %0d pending expected 0", exp_err_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule